// File: doc/BRIEF.md
# UART Modem Control and Loopback Unit

This unit holds the per-channel modem control byte of a UART. It turns that byte into the active-low request-to-send and terminal-ready pin levels, a general-purpose output, an interrupt-output enable, a clock prescaler select and two feature enables for neighbouring logic. The three upper bits of the byte are guarded. They change only while the enhanced-feature unlock input is high.

One bit selects internal loopback. In loopback the serial transmit stream goes back into the receiver, and the external transmit pin idles high. The external control pins are parked inactive. The four upper modem status bits are then rebuilt from the control bits through a fixed cross-map. Outside loopback, those status bits show the inverted levels of the four modem input pins. An auto-flow-control override can take over the request-to-send pin.

Top module: `mdm_ctl_unit`

## Requirements
- R1: An active-low asynchronous reset clears the control byte. All enables then read 0, loopback is off, and req_to_send_no, term_rdy_no and gp_out_no are all 1.
- R2: Bits 4..0 of the control byte take wr_data_i at a rising clock edge where wr_en_i is 1. When wr_en_i is 0, the byte holds.
- R3: Bits 7..5 take wr_data_i on a write only when unlock_i is 1. Otherwise they keep their value.
- R4: Bit 7 drives clk_div4_o (1 selects divide-by-4), bit 6 drives aux_bank_en_o, bit 5 drives any_resume_en_o and bit 2 drives fifo_rdy_en_o.
- R5: Outside loopback, with auto_req_en_i at 0, req_to_send_no is the inverse of bit 1.
- R6: Outside loopback, with auto_req_en_i at 1, req_to_send_no follows auto_req_ni.
- R7: Outside loopback, term_rdy_no is the inverse of bit 0.
- R8: irq_oe_o equals bit 3. Outside loopback, gp_out_no is the inverse of bit 3.
- R9: Bit 4 set selects loopback. tx_ser_o is then held at 1 and rx_ser_o carries tx_ser_i. Outside loopback, tx_ser_o carries tx_ser_i and rx_ser_o carries rx_ser_i.
- R10: In loopback, modem_stat_o = {bit3, bit2, bit0, bit1}, where modem_stat_o[3:0] stands for status bits 7..4. The modem input pins have no effect on it.
- R11: In loopback, req_to_send_no, term_rdy_no and gp_out_no are all 1.
- R12: Outside loopback, modem_stat_o = ~{carrier_ni, ring_ni, set_rdy_ni, clr_send_ni}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control byte |
| wr_data_i | input | 8 | Write data |
| unlock_i | input | 1 | Enhanced-feature unlock for bits 7..5 |
| auto_req_en_i | input | 1 | Hardware flow control owns request-to-send |
| auto_req_ni | input | 1 | Request-to-send level from hardware flow control |
| clr_send_ni | input | 1 | Clear-to-send pin, active low |
| set_rdy_ni | input | 1 | Data-set-ready pin, active low |
| ring_ni | input | 1 | Ring indicator pin, active low |
| carrier_ni | input | 1 | Carrier detect pin, active low |
| tx_ser_i | input | 1 | Serial stream from the transmitter |
| rx_ser_i | input | 1 | Serial stream from the receive pin |
| tx_ser_o | output | 1 | Transmit pin |
| rx_ser_o | output | 1 | Serial stream to the receiver |
| req_to_send_no | output | 1 | Request-to-send pin, active low |
| term_rdy_no | output | 1 | Terminal-ready pin, active low |
| gp_out_no | output | 1 | General-purpose output, active low |
| irq_oe_o | output | 1 | Interrupt outputs enabled (0 = high impedance) |
| clk_div4_o | output | 1 | Prescaler select, 1 = divide by 4 |
| aux_bank_en_o | output | 1 | Access enable for transmit-control and trigger-level registers |
| any_resume_en_o | output | 1 | Resume-on-any-character enable |
| fifo_rdy_en_o | output | 1 | FIFO-ready status register enable |
| loop_en_o | output | 1 | Loopback active |
| modem_stat_o | output | 4 | Modem status bits 7..4 |

## Verification
Some behaviours are checked by assertions on every cycle. These are the write protection of the upper bits, the capture and hold of the lower bits, the parked pins and serial routing in loopback, the loopback status cross-map, and the complementary interrupt-enable and general-purpose levels. Other behaviours only show up in the bench scenarios. They are the reset values, the asynchronous clear between clock edges, the auto-flow override taking req_to_send_no, the pins being ignored while looped, and protected bits surviving several locked writes in a row.

// File: rtl/mdm_ctl_pkg.sv
package mdm_ctl_pkg;
  localparam int CTL_W   = 8;
  localparam int PROT_LO = 5;
  localparam int B_DIV4  = 7;
  localparam int B_BANK  = 6;
  localparam int B_RESUM = 5;
  localparam int B_LOOP  = 4;
  localparam int B_IRQ   = 3;
  localparam int B_FRDY  = 2;
  localparam int B_REQ   = 1;
  localparam int B_TERM  = 0;

  typedef struct packed {
    logic carrier;
    logic ring;
    logic set_rdy;
    logic clr_send;
  } mstat_t;
endpackage

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg #(
  parameter int W       = 8,
  parameter int PROT_LO = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic         unlock_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] ctl_q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic we;
    if (i >= PROT_LO) begin : g_prot
      assign we = wr_en_i & unlock_i;
    end else begin : g_open
      assign we = wr_en_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  ctl_q_o[i] <= 1'b0;
      else if (we)  ctl_q_o[i] <= wr_data_i[i];
    end
  end

  p_lock_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !unlock_i) |=> ctl_q_o[W-1:PROT_LO] == $past(ctl_q_o[W-1:PROT_LO]));
  p_low_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ctl_q_o[PROT_LO-1:0] == $past(wr_data_i[PROT_LO-1:0]));
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ctl_q_o));
endmodule

// File: rtl/mdm_loop_route.sv
module mdm_loop_route
  import mdm_ctl_pkg::*;
(
  input  logic       loop_en_i,
  input  logic [3:0] ctl_lo_i,
  input  mstat_t     pins_n_i,
  input  logic       tx_ser_i,
  input  logic       rx_ser_i,
  output mstat_t     stat_o,
  output logic       tx_ser_o,
  output logic       rx_ser_o
);
  mstat_t loop_stat;

  // fixed cross-map: irq->carrier, frdy->ring, term->set_rdy, req->clr_send
  always_comb begin
    loop_stat.carrier  = ctl_lo_i[B_IRQ];
    loop_stat.ring     = ctl_lo_i[B_FRDY];
    loop_stat.set_rdy  = ctl_lo_i[B_TERM];
    loop_stat.clr_send = ctl_lo_i[B_REQ];
  end

  assign stat_o   = loop_en_i ? loop_stat : ~pins_n_i;
  assign tx_ser_o = loop_en_i | tx_ser_i;
  assign rx_ser_o = loop_en_i ? tx_ser_i : rx_ser_i;
endmodule

// File: rtl/mdm_pin_drive.sv
module mdm_pin_drive (
  input  logic loop_en_i,
  input  logic req_i,
  input  logic term_i,
  input  logic irq_i,
  input  logic auto_en_i,
  input  logic auto_ni,
  output logic req_no,
  output logic term_no,
  output logic gp_no,
  output logic irq_oe_o
);
  logic req_n_int;

  assign req_n_int = auto_en_i ? auto_ni : ~req_i;
  assign req_no    = loop_en_i | req_n_int;
  assign term_no   = loop_en_i | ~term_i;
  assign gp_no     = loop_en_i | ~irq_i;
  assign irq_oe_o  = irq_i;
endmodule

// File: rtl/mdm_ctl_unit.sv
module mdm_ctl_unit
  import mdm_ctl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       unlock_i,
  input  logic       auto_req_en_i,
  input  logic       auto_req_ni,
  input  logic       clr_send_ni,
  input  logic       set_rdy_ni,
  input  logic       ring_ni,
  input  logic       carrier_ni,
  input  logic       tx_ser_i,
  input  logic       rx_ser_i,
  output logic       tx_ser_o,
  output logic       rx_ser_o,
  output logic       req_to_send_no,
  output logic       term_rdy_no,
  output logic       gp_out_no,
  output logic       irq_oe_o,
  output logic       clk_div4_o,
  output logic       aux_bank_en_o,
  output logic       any_resume_en_o,
  output logic       fifo_rdy_en_o,
  output logic       loop_en_o,
  output logic [3:0] modem_stat_o
);
  logic [CTL_W-1:0] ctl_q;
  mstat_t           pins_n, stat;

  mdm_ctl_reg #(.W(CTL_W), .PROT_LO(PROT_LO)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .unlock_i  (unlock_i),
    .wr_data_i (wr_data_i),
    .ctl_q_o   (ctl_q)
  );

  assign pins_n = '{carrier: carrier_ni, ring: ring_ni, set_rdy: set_rdy_ni, clr_send: clr_send_ni};

  mdm_loop_route u_route (
    .loop_en_i (ctl_q[B_LOOP]),
    .ctl_lo_i  (ctl_q[3:0]),
    .pins_n_i  (pins_n),
    .tx_ser_i  (tx_ser_i),
    .rx_ser_i  (rx_ser_i),
    .stat_o    (stat),
    .tx_ser_o  (tx_ser_o),
    .rx_ser_o  (rx_ser_o)
  );

  mdm_pin_drive u_drive (
    .loop_en_i (ctl_q[B_LOOP]),
    .req_i     (ctl_q[B_REQ]),
    .term_i    (ctl_q[B_TERM]),
    .irq_i     (ctl_q[B_IRQ]),
    .auto_en_i (auto_req_en_i),
    .auto_ni   (auto_req_ni),
    .req_no    (req_to_send_no),
    .term_no   (term_rdy_no),
    .gp_no     (gp_out_no),
    .irq_oe_o  (irq_oe_o)
  );

  assign clk_div4_o      = ctl_q[B_DIV4];
  assign aux_bank_en_o   = ctl_q[B_BANK];
  assign any_resume_en_o = ctl_q[B_RESUM];
  assign fifo_rdy_en_o   = ctl_q[B_FRDY];
  assign loop_en_o       = ctl_q[B_LOOP];
  assign modem_stat_o    = stat;

  p_loop_pins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_en_o |-> (req_to_send_no && term_rdy_no && gp_out_no));
  p_loop_serial_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_en_o |-> (tx_ser_o && (rx_ser_o == tx_ser_i)));
  p_loop_map_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_en_o |-> modem_stat_o == {ctl_q[B_IRQ], ctl_q[B_FRDY], ctl_q[B_TERM], ctl_q[B_REQ]});
  p_irq_gp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loop_en_o |-> (gp_out_no != irq_oe_o));
endmodule

// File: tb/mdm_ctl_unit_tb_top.sv
`timescale 1ns/1ps
module mdm_ctl_unit_tb_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en = 1'b0, unlock = 1'b0, auto_en = 1'b0, auto_n = 1'b1;
  logic [7:0] wr_data = '0;
  logic [3:0] pins_n = 4'hF;  // {carrier, ring, set_rdy, clr_send}
  logic tx_i = 1'b1, rx_i = 1'b1;
  logic tx_o, rx_o, req_n, term_n, gp_n, irq_oe, div4, bank, resum, frdy, loop_en;
  logic [3:0] stat;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  mdm_ctl_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .unlock_i(unlock), .auto_req_en_i(auto_en), .auto_req_ni(auto_n),
    .clr_send_ni(pins_n[0]), .set_rdy_ni(pins_n[1]), .ring_ni(pins_n[2]),
    .carrier_ni(pins_n[3]), .tx_ser_i(tx_i), .rx_ser_i(rx_i),
    .tx_ser_o(tx_o), .rx_ser_o(rx_o), .req_to_send_no(req_n),
    .term_rdy_no(term_n), .gp_out_no(gp_n), .irq_oe_o(irq_oe),
    .clk_div4_o(div4), .aux_bank_en_o(bank), .any_resume_en_o(resum),
    .fifo_rdy_en_o(frdy), .loop_en_o(loop_en), .modem_stat_o(stat)
  );

  // {div4,bank,resum,loop,irq_oe,frdy,req_n,term_n,gp_n,tx_o,rx_o,stat[3:0]}
  logic [14:0] obs;
  assign obs = {div4, bank, resum, loop_en, irq_oe, frdy, req_n, term_n, gp_n, tx_o, rx_o, stat};

  typedef struct packed {
    logic        unl;
    logic        aen;
    logic        an;
    logic [7:0]  data;
    logic [3:0]  pn;
    logic        tx;
    logic        rx;
    logic [14:0] exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b1, 8'hE0, 4'b1111, 1'b0, 1'b1, 15'b111_000_111_01_0000},
    '{1'b0, 1'b0, 1'b1, 8'h0B, 4'b0101, 1'b1, 1'b0, 15'b111_010_000_10_1010},
    '{1'b0, 1'b0, 1'b1, 8'h04, 4'b1010, 1'b1, 1'b1, 15'b111_001_111_11_0101},
    '{1'b1, 1'b1, 1'b0, 8'h40, 4'b0000, 1'b0, 1'b0, 15'b010_000_011_00_1111},
    '{1'b1, 1'b1, 1'b0, 8'h1B, 4'b0000, 1'b0, 1'b1, 15'b000_110_111_10_1011},
    '{1'b0, 1'b0, 1'b1, 8'h16, 4'b1111, 1'b1, 1'b0, 15'b000_101_111_11_0101},
    '{1'b0, 1'b0, 1'b1, 8'h11, 4'b0000, 1'b0, 1'b1, 15'b000_100_111_10_0010},
    '{1'b0, 1'b0, 1'b1, 8'hE3, 4'b0110, 1'b1, 1'b0, 15'b000_000_001_10_1001}
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R3 R4";
      1: return "R3 R5 R7 R8 R12";
      2: return "R3 R4 R8";
      3: return "R4 R6";
      4: return "R9 R10 R11";
      5: return "R3 R10";
      6: return "R9 R10";
      default: return "R3 R5 R7 R12";
    endcase
  endfunction

  task automatic chk(string tag, logic [14:0] act, logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wr(logic u, logic [7:0] d);
    @(negedge clk);
    unlock = u; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset state", obs, 15'b000_000_111_11_0000);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      auto_en = VECS[i].aen; auto_n = VECS[i].an; pins_n = VECS[i].pn;
      tx_i = VECS[i].tx; rx_i = VECS[i].rx;
      wr(VECS[i].unl, VECS[i].data);
      chk(vec_tag(i), obs, VECS[i].exp);
    end

    // R2: data change without strobe leaves state as after last vector
    @(negedge clk);
    unlock = 1'b1; wr_data = 8'hFF;
    repeat (2) @(negedge clk);
    #1;
    chk("R2 no strobe", obs, 15'b000_000_001_10_1001);

    // R10: pins ignored in loopback (control byte 0x10 -> all mapped bits 0)
    wr(1'b1, 8'h10);
    pins_n = 4'b0000; #1;
    chk("R10 loop pins low", {11'd0, stat}, 15'd0);
    pins_n = 4'b1111; #1;
    chk("R10 loop pins high", {11'd0, stat}, 15'd0);

    // R6: auto override flips req pin with bit 1 at 0
    auto_en = 1'b1; auto_n = 1'b1;
    wr(1'b1, 8'h00);
    chk("R6 auto high", {14'd0, req_n}, 15'd1);
    auto_n = 1'b0; #1;
    chk("R6 auto low", {14'd0, req_n}, 15'd0);
    auto_n = 1'b1; auto_en = 1'b0; #1;
    chk("R5 manual inactive", {14'd0, req_n}, 15'd1);

    // R1: asynchronous clear between edges, upper bits included
    wr(1'b1, 8'hFF);
    @(negedge clk);
    #3 rst_ni = 1'b0;
    #2;
    chk("R1 async clear", {9'd0, div4, bank, resum, loop_en, irq_oe, frdy}, 15'd0);
    chk("R1 async pins", {12'd0, req_n, term_n, gp_n}, 15'b111);
    @(negedge clk);
    rst_ni = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule